// File: doc/BRIEF.md
# Compare-Driven Output Port

The block owns a free-running 16-bit up-counter and three 16-bit compare registers. Each compare channel has a fixed job. Channel 0 drives high the low six port pins that it is enabled for. Channel 1 drives those same pins low. Channel 2 inverts the two top pins. Each pin has its own enable bit, so software chooses which pins follow which event. A pin whose enable bit is clear keeps its value.

Software reaches the block through a small synchronous write/read bus. Through it, software loads the compare bytes, the two enable registers and the port value, and it can read the counter. A compare event lasts exactly one clock, on the first cycle that the counter equals the compare value. The port is a register, and the top two bits of the set-enable register report two toggle status flags.

Top module: `cmp_port_unit`

## Requirements
- R1: After a synchronous active-high reset, the counter, all compare bytes, both enable registers, the toggle flags, the port and the read data are 0.
- R2: The counter increments by one on each clock while `tmr_en` is 1, holds while it is 0, and wraps from 0xFFFF to 0x0000.
- R3: On a channel-0 event, each pin i (0..5) whose bit i in the set-enable register (address 6) is 1 becomes 1 at the next clock edge.
- R4: On a channel-1 event, each pin i (0..5) whose bit i in the clear-enable register (address 7) is 1 becomes 0.
- R5: On a channel-2 event, pin 6 inverts if clear-enable bit 6 is 1, and pin 7 inverts if clear-enable bit 7 is 1. Toggle flag 0 (set-enable readback bit 6) and toggle flag 1 (bit 7) invert under the same conditions.
- R6: A pin whose enable bit is 0 is not changed by a compare event.
- R7: A channel event is raised only on the first cycle that the counter equals the compare value. While the counter is held on that value, no further event occurs.
- R8: If channel 0 and channel 1 events hit the same pin in the same cycle, the pin ends at 0.
- R9: A bus write to the port register (address 8) loads all eight pins, except pins acted on by a compare event in that same cycle, which take the compare result.
- R10: Bits 7:6 of the set-enable register are read-only toggle flags. Bus writes do not change them.
- R11: Address map, with read data registered one clock after the address is presented: 0..5 hold the compare bytes (channel c low byte at 2c, high byte at 2c+1); 6 holds the set-enable register; 7 holds the clear-enable register; 8 holds the port; 9 and 10 return the counter's low and high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_o | output | 8 | Registered output port |

## Verification
The bench aims at the following cases:
- Simultaneous set and clear events on the same pins. A design with the wrong priority would leave those pins high.
- A compare value that matches while the counter is stopped. A level-sensitive match would keep re-setting a pin after software has cleared it.
- A port write that lands in the same cycle as a clear event. A design that lets the bus win would keep the written 1s.
- A long run through the counter wrap, and bus writes aimed at the read-only toggle flags. These catch a counter that saturates, and flags that software can corrupt.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int BYTE_W = 8;
  localparam int N_CMP  = 3;
  typedef enum logic [1:0] {ROLE_SET = 2'd0, ROLE_CLR = 2'd1, ROLE_TGL = 2'd2} cmp_role_e;
endpackage

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == W'($past(cnt) + 1'b1)); // R2
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R2
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         hit
);
  logic eq, eq_q;
  assign eq  = (cnt == cmp);
  assign hit = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit); // R7
  AST_HIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (hit && $stable(cnt)) |=> ($stable(cnt) && $stable(cmp)) |-> !hit); // R7
endmodule

// File: rtl/cmp_regfile.sv
module cmp_regfile #(
  parameter int TMR_W  = 16,
  parameter int DATA_W = 8,
  parameter int N_CMP  = 3,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [DATA_W-1:0]             port_q,
  input  logic [1:0]                    tgl_flag,
  input  logic [TMR_W-1:0]              tmr,
  output logic [N_CMP-1:0][TMR_W-1:0]   cmp,
  output logic [DATA_W-3:0]             set_en,
  output logic [DATA_W-1:0]             clr_en,
  output logic                          port_we,
  output logic [DATA_W-1:0]             rdata
);
  localparam int BYTES  = TMR_W / cmp_pkg::BYTE_W;
  localparam int NB     = N_CMP * BYTES;
  localparam int A_SET  = NB;
  localparam int A_CLR  = NB + 1;
  localparam int A_PORT = NB + 2;
  localparam int A_TMR  = NB + 3;

  logic [NB-1:0][cmp_pkg::BYTE_W-1:0] cbytes;
  logic [DATA_W-1:0] rd_nxt;

  for (genvar c = 0; c < N_CMP; c++) begin : g_ch
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign cmp[c][b*cmp_pkg::BYTE_W +: cmp_pkg::BYTE_W] = cbytes[c*BYTES + b];
    end
  end

  assign port_we = we && (addr == ADDR_W'(A_PORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cbytes <= '0;
      set_en <= '0;
      clr_en <= '0;
    end else if (we) begin
      for (int k = 0; k < NB; k++)
        if (addr == ADDR_W'(k)) cbytes[k] <= wdata;
      if (addr == ADDR_W'(A_SET)) set_en <= wdata[DATA_W-3:0];
      if (addr == ADDR_W'(A_CLR)) clr_en <= wdata;
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NB; k++)
      if (addr == ADDR_W'(k)) rd_nxt = cbytes[k];
    for (int b = 0; b < BYTES; b++)
      if (addr == ADDR_W'(A_TMR + b)) rd_nxt = tmr[b*cmp_pkg::BYTE_W +: cmp_pkg::BYTE_W];
    if (addr == ADDR_W'(A_SET))  rd_nxt = {tgl_flag, set_en};
    if (addr == ADDR_W'(A_CLR))  rd_nxt = clr_en;
    if (addr == ADDR_W'(A_PORT)) rd_nxt = port_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/cmp_pindrv.sv
module cmp_pindrv #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_set,
  input  logic              hit_clr,
  input  logic              hit_tgl,
  input  logic [PORT_W-3:0] set_en,
  input  logic [PORT_W-1:0] clr_en,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_data,
  output logic [PORT_W-1:0] port_q,
  output logic [1:0]        tgl_flag
);
  localparam int SET_N = PORT_W - 2;

  logic [PORT_W-1:0] port_nxt;
  logic [1:0]        tgl_mask;

  assign tgl_mask = hit_tgl ? clr_en[PORT_W-1 -: 2] : 2'b00;

  always_comb begin
    port_nxt = bus_we ? bus_data : port_q;
    for (int i = 0; i < SET_N; i++) begin
      if (hit_clr && clr_en[i])      port_nxt[i] = 1'b0;
      else if (hit_set && set_en[i]) port_nxt[i] = 1'b1;
    end
    for (int j = 0; j < 2; j++)
      if (tgl_mask[j]) port_nxt[SET_N+j] = ~port_q[SET_N+j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q   <= '0;
      tgl_flag <= '0;
    end else begin
      port_q   <= port_nxt;
      tgl_flag <= tgl_flag ^ tgl_mask;
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit_set && hit_clr) |=> (port_q[SET_N-1:0] & $past(clr_en[SET_N-1:0])) == '0); // R8
  AST_SET_PINS: assert property (@(posedge clk) disable iff (rst)
    (hit_set && !hit_clr) |=> (port_q[SET_N-1:0] & $past(set_en)) == $past(set_en)); // R3
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
    hit_tgl |=> ((port_q[PORT_W-1 -: 2] ^ $past(port_q[PORT_W-1 -: 2])) & $past(clr_en[PORT_W-1 -: 2]))
                == $past(clr_en[PORT_W-1 -: 2])); // R5
  AST_PIN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (hit_set && !hit_clr && !bus_we) |=> ((port_q[SET_N-1:0] ^ $past(port_q[SET_N-1:0])) & ~$past(set_en)) == '0); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit_tgl |=> $stable(tgl_flag)); // R10
endmodule

// File: rtl/cmp_port_unit.sv
module cmp_port_unit #(
  parameter int TMR_W  = 16,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] port_o
);
  import cmp_pkg::*;

  logic [TMR_W-1:0]             tmr;
  logic [N_CMP-1:0][TMR_W-1:0]  cmp;
  logic [N_CMP-1:0]             hit;
  logic [PORT_W-3:0]            set_en;
  logic [PORT_W-1:0]            clr_en;
  logic                         port_we;
  logic [1:0]                   tgl_flag;

  cmp_timer #(.W(TMR_W)) u_tmr (.clk(clk), .rst(rst), .en(tmr_en), .cnt(tmr));

  for (genvar c = 0; c < N_CMP; c++) begin : g_match
    cmp_match #(.W(TMR_W)) u_match (
      .clk(clk), .rst(rst), .cnt(tmr), .cmp(cmp[c]), .hit(hit[c])
    );
  end

  cmp_regfile #(.TMR_W(TMR_W), .DATA_W(PORT_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .port_q(port_o), .tgl_flag(tgl_flag), .tmr(tmr), .cmp(cmp),
    .set_en(set_en), .clr_en(clr_en), .port_we(port_we), .rdata(bus_rdata)
  );

  cmp_pindrv #(.PORT_W(PORT_W)) u_pins (
    .clk(clk), .rst(rst),
    .hit_set(hit[ROLE_SET]), .hit_clr(hit[ROLE_CLR]), .hit_tgl(hit[ROLE_TGL]),
    .set_en(set_en), .clr_en(clr_en), .bus_we(port_we), .bus_data(bus_wdata),
    .port_q(port_o), .tgl_flag(tgl_flag)
  );
endmodule

// File: tb/tb_cmp_port_unit.sv
module tb_cmp_port_unit;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, port_o;

  cmp_port_unit dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  string cur_tag = "R1";
  bit done = 0;

  // reference model
  logic [15:0] m_tmr;
  logic [15:0] m_cmp [3];
  logic [5:0]  m_set;
  logic [7:0]  m_clr, m_port, m_rd;
  logic [1:0]  m_flag;
  logic [2:0]  m_eqq;

  function automatic logic [7:0] model_read(logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return a[0] ? m_cmp[a/2][15:8] : m_cmp[a/2][7:0];
      4'd6:  return {m_flag, m_set};
      4'd7:  return m_clr;
      4'd8:  return m_port;
      4'd9:  return m_tmr[7:0];
      4'd10: return m_tmr[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] h;
    logic [7:0] np;
    if (rst) begin
      m_tmr = 0; m_set = 0; m_clr = 0; m_port = 0; m_rd = 0; m_flag = 0; m_eqq = 0;
      for (int c = 0; c < 3; c++) m_cmp[c] = 0;
    end else begin
      m_rd = model_read(bus_addr);
      for (int c = 0; c < 3; c++) h[c] = (m_tmr == m_cmp[c]) && !m_eqq[c];
      for (int c = 0; c < 3; c++) m_eqq[c] = (m_tmr == m_cmp[c]);
      np = (bus_we && bus_addr == 4'd8) ? bus_wdata : m_port;
      for (int i = 0; i < 6; i++) begin
        if (h[1] && m_clr[i])      np[i] = 1'b0;
        else if (h[0] && m_set[i]) np[i] = 1'b1;
      end
      for (int j = 0; j < 2; j++)
        if (h[2] && m_clr[6+j]) begin np[6+j] = ~m_port[6+j]; m_flag[j] = ~m_flag[j]; end
      m_port = np;
      if (bus_we) begin
        if (bus_addr < 4'd6) begin
          if (bus_addr[0]) m_cmp[bus_addr/2][15:8] = bus_wdata;
          else             m_cmp[bus_addr/2][7:0]  = bus_wdata;
        end
        if (bus_addr == 4'd6) m_set = bus_wdata[5:0];
        if (bus_addr == 4'd7) m_clr = bus_wdata;
      end
      if (tmr_en) m_tmr = m_tmr + 1'b1;
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check at the next negedge
  task automatic cyc(bit en, bit we, logic [3:0] a, logic [7:0] d);
    tmr_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    chk(cur_tag, "port", port_o, m_port);
    chk(cur_tag, "rdata", bus_rdata, m_rd);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); cyc(1'b0, 1'b1, a, d); endtask
  task automatic wr_cmp(int c, logic [15:0] v);
    wr(4'(2*c), v[7:0]); wr(4'(2*c+1), v[15:8]);
  endtask
  task automatic run(int n); for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'd8, 8'h00); endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] t;
    void'($urandom(32'd7141));
    @(negedge clk); @(negedge clk);
    cur_tag = "R1";
    chk("R1", "port after reset", port_o, 8'h00);
    chk("R1", "rdata after reset", bus_rdata, 8'h00);
    rst = 1'b0;
    for (int a = 0; a <= 10; a++) cyc(1'b0, 1'b0, 4'(a), 8'h00);

    // R11: write/readback of all writable registers
    cur_tag = "R11";
    for (int a = 0; a < 8; a++) wr(4'(a), 8'(8'h11 * (a + 1)));
    for (int a = 0; a <= 10; a++) cyc(1'b0, 1'b0, 4'(a), 8'h00);
    // R10: flags are read-only
    cur_tag = "R10";
    wr(4'd7, 8'h00); wr(4'd6, 8'hFF); cyc(1'b0, 1'b0, 4'd6, 8'h00);
    cyc(1'b0, 1'b0, 4'd6, 8'h00);
    chk("R10", "flags after write", bus_rdata, 8'h3F);

    // R3 / R6: set pins 0,2,4 only
    cur_tag = "R3";
    for (int c = 0; c < 3; c++) wr_cmp(c, 16'hF000);
    wr(4'd6, 8'h15); wr(4'd7, 8'h00); wr(4'd8, 8'h00);
    wr_cmp(0, m_tmr + 16'd4);
    run(6);
    chk("R6", "unenabled pins untouched", port_o, 8'h15);

    // R4: clear pins 2,3
    cur_tag = "R4";
    wr(4'd6, 8'h00); wr(4'd7, 8'h0C); wr(4'd8, 8'h3F);
    wr_cmp(1, m_tmr + 16'd4);
    run(6);
    chk("R4", "cleared pins", port_o, 8'h33);

    // R5: toggle both top pins and flags
    cur_tag = "R5";
    wr(4'd7, 8'hC0); wr(4'd8, 8'h40);
    wr_cmp(2, m_tmr + 16'd3);
    run(5);
    chk("R5", "toggled pins", port_o, 8'h80);
    cyc(1'b0, 1'b0, 4'd6, 8'h00); cyc(1'b0, 1'b0, 4'd6, 8'h00);
    chk("R5", "toggle flags", bus_rdata, 8'hC0);

    // R7: held counter matches once
    cur_tag = "R7";
    wr(4'd7, 8'h00); wr(4'd6, 8'h01); wr_cmp(0, 16'h0000);
    wr(4'd0, m_tmr[7:0]); wr(4'd1, m_tmr[15:8]);
    wr(4'd8, 8'h00);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 4'd8, 8'h00);
    chk("R7", "no repeat while held", port_o, 8'h00);

    // R8: set and clear together
    cur_tag = "R8";
    wr(4'd6, 8'h3F); wr(4'd7, 8'h3F); wr(4'd8, 8'h00);
    t = m_tmr + 16'd5;
    wr_cmp(0, t); wr_cmp(1, t);
    run(5);
    chk("R8", "clear wins", port_o, 8'h00);

    // R9: port write in same cycle as a clear event
    cur_tag = "R9";
    wr(4'd6, 8'h00); wr(4'd7, 8'h03);
    wr_cmp(1, m_tmr + 16'd3);
    run(3);
    cyc(1'b1, 1'b1, 4'd8, 8'hFF);
    chk("R9", "compare beats bus write", port_o, 8'hFC);

    // mixed random traffic
    cur_tag = "R3 R4 R5 R9 random";
    for (int n = 0; n < 1500; n++) begin
      int r; logic [15:0] v;
      r = int'($urandom % 8);
      v = m_tmr + 16'($urandom % 16);
      case (r)
        0, 1, 2: cyc(1'($urandom), 1'b0, 4'($urandom % 11), 8'h00);
        3: begin int a = int'($urandom % 6); wr(4'(a), a[0] ? v[15:8] : v[7:0]); end
        4: wr(4'd6, 8'($urandom));
        5: wr(4'd7, 8'($urandom));
        6: wr(4'd8, 8'($urandom));
        default: cyc(1'b1, 1'b0, 4'($urandom % 11), 8'h00);
      endcase
    end

    // R2: full run through the wrap
    cur_tag = "R2";
    for (int n = 0; n < 66000; n++) cyc(1'b1, 1'b0, 4'(9 + (n % 2)), 8'h00);
    cyc(1'b0, 1'b0, 4'd9, 8'h00);
    for (int n = 0; n < 3; n++) cyc(1'b0, 1'b0, 4'd10, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule